// File: doc/BRIEF.md
# Trigger Input Conditioner

This block sits between a comparator that has already digitised an external trigger signal and a delay timer. It brings the asynchronous level into the clock domain, picks out the transitions of the selected direction and drops them while an inhibit input is high. Each transition it accepts produces three outputs. The first is a single-cycle pulse that marks time zero for the delay timer. The second is a longer stretched pulse that a slower control domain can sample safely. The third is a hold signal long enough to drive a visible trigger lamp.

Three small state machines do the work. The edge tracker has states `LVL_LOW` and `LVL_HIGH`, which hold the last synchronised level. It moves `LVL_LOW`→`LVL_HIGH` when the level rises and `LVL_HIGH`→`LVL_LOW` when it falls, and it stays in its state otherwise. Each of the two hold machines has states `HOLD_IDLE` and `HOLD_BUSY`. An accepted trigger moves a hold machine `HOLD_IDLE`→`HOLD_BUSY` and loads its counter. Inside `HOLD_BUSY`, a fresh trigger reloads the counter without a state change. When the counter reaches zero, the machine returns `HOLD_BUSY`→`HOLD_IDLE`. One hold machine instance drives the stretched output and the other drives the indicator.

Top module: `trig_conditioner`

## Requirements
- R1: With `slope_fall` = 0, a low-to-high change of `trig_in` made before clock edge k gives `fire_pulse` high from edge k+2: two synchroniser flops plus one output register.
- R2: With `slope_fall` = 1, a high-to-low change of `trig_in` gives `fire_pulse` with the same latency as R1.
- R3: If `inhibit` is high at the clock edge where the synchronised transition is evaluated (edge k+2), no `fire_pulse`, no stretch start or restart and no indicator start or restart results from that transition.
- R4: `fire_pulse` is high for exactly one clock cycle for each accepted transition.
- R5: `stretch_out` goes high in the same cycle as `fire_pulse` and stays high for `STRETCH_LEN` cycles.
- R6: An accepted trigger while `stretch_out` is high restarts the count, so the output stays high for `STRETCH_LEN` cycles counted from the newest trigger.
- R7: `indicator` goes high with `fire_pulse` and stays high for `IND_LEN` cycles counted from the newest accepted trigger, so it is retriggerable.
- R8: A transition in the direction that was not selected, including one caused by changing the idle level when the slope is switched, produces no output.
- R9: While `rst_n` is low, `fire_pulse`, `stretch_out` and `indicator` are low, and the edge tracker returns to `LVL_LOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Digitised external trigger level, asynchronous |
| slope_fall | input | 1 | 0: rising transitions trigger, 1: falling transitions trigger |
| inhibit | input | 1 | High blocks acceptance of triggers |
| fire_pulse | output | 1 | One-cycle trigger for the delay timer |
| stretch_out | output | 1 | Stretched trigger for the slow domain |
| indicator | output | 1 | Trigger lamp drive, held after each trigger |

## Verification
The bench sweeps pulse widths down to one cycle and gaps shorter than the stretch length, using both slopes and with inhibit off, on and toggling every cycle. A design with an off-by-one in the synchroniser depth or in the hold count would move or clip the pulses against the bench's cycle model. A stretcher that ignores retriggers would drop `stretch_out` early during closely spaced triggers. An inhibit sampled at the wrong stage would let a trigger through whenever the toggling inhibit pattern happened to be low at the wrong edge. A mid-run reset while both holds are busy checks that nothing survives the reset, and slope switches with the input idle show whether a transition in the unselected direction leaks through.

// File: rtl/trigcond_pkg.sv
package trigcond_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    typedef enum logic {
        HOLD_IDLE = 1'b0,
        HOLD_BUSY = 1'b1
    } hold_state_e;
endpackage

// File: rtl/trigcond_sync.sv
module trigcond_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/trigcond_edge.sv
module trigcond_edge
    import trigcond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic slope_fall,
    input  logic inhibit,
    output logic accept,
    output logic fire
);
    lvl_state_e state_q, state_d;
    logic       rise_seen, fall_seen;

    // next-state process
    always_comb begin
        state_d   = state_q;
        rise_seen = 1'b0;
        fall_seen = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (level) begin
                    state_d   = LVL_HIGH;
                    rise_seen = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!level) begin
                    state_d   = LVL_LOW;
                    fall_seen = 1'b1;
                end
            end
            default: state_d = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // output process
    assign accept = (slope_fall ? fall_seen : rise_seen) & ~inhibit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire <= 1'b0;
        else        fire <= accept;
    end
endmodule

// File: rtl/trigcond_hold.sv
module trigcond_hold
    import trigcond_pkg::*;
#(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(LEN - 1);

    hold_state_e     state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HOLD_IDLE: begin
                if (start) begin
                    state_d = HOLD_BUSY;
                    cnt_d   = RELOAD;
                end
            end
            HOLD_BUSY: begin
                if (start) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    state_d = HOLD_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign active = (state_q == HOLD_BUSY);
endmodule

// File: rtl/trig_conditioner.sv
module trig_conditioner #(
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH_LEN = 16,
    parameter int IND_LEN     = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic slope_fall,
    input  logic inhibit,
    output logic fire_pulse,
    output logic stretch_out,
    output logic indicator
);
    logic lvl_sync;
    logic accept;

    trigcond_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .sync_out (lvl_sync)
    );

    trigcond_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (lvl_sync),
        .slope_fall (slope_fall),
        .inhibit    (inhibit),
        .accept     (accept),
        .fire       (fire_pulse)
    );

    trigcond_hold #(.LEN(STRETCH_LEN)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .active (stretch_out)
    );

    trigcond_hold #(.LEN(IND_LEN)) u_lamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .active (indicator)
    );
endmodule

// File: rtl/trigcond_checker.sv
module trigcond_checker (
    input logic clk,
    input logic rst_n,
    input logic inhibit,
    input logic fire_pulse,
    input logic stretch_out,
    input logic indicator
);
    // R4: never two fire cycles in a row
    p_single_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_pulse |=> !fire_pulse);

    // R3: a fire needs inhibit low at the accepting edge
    p_inhibit_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_pulse |-> !$past(inhibit));

    // R5: stretch starts together with fire
    p_stretch_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_pulse |-> stretch_out);

    // R6: stretch cannot end right after a fresh trigger
    p_stretch_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stretch_out) |-> !$past(fire_pulse));

    // R7: indicator lit whenever fire is
    p_lamp_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_pulse |-> indicator);

    // R9: outputs cleared during reset
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |-> (!fire_pulse && !stretch_out && !indicator));
endmodule

bind trig_conditioner trigcond_checker u_trigcond_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .inhibit     (inhibit),
    .fire_pulse  (fire_pulse),
    .stretch_out (stretch_out),
    .indicator   (indicator)
);

// File: tb/test_trig_conditioner.sv
`timescale 1ns/1ps
module test_trig_conditioner;
    localparam int SL = 4;
    localparam int IL = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic slope_fall = 1'b0;
    logic inhibit = 1'b0;
    logic fire_pulse, stretch_out, indicator;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trig_conditioner #(.SYNC_STAGES(2), .STRETCH_LEN(SL), .IND_LEN(IL)) i_trig_conditioner (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .slope_fall(slope_fall),
        .inhibit(inhibit), .fire_pulse(fire_pulse), .stretch_out(stretch_out),
        .indicator(indicator)
    );

    // cycle model built from the requirements
    logic [2:0] msh;
    logic       efire;
    int         ecs, eci;
    logic       macc;
    assign macc = (slope_fall ? (!msh[1] && msh[2]) : (msh[1] && !msh[2])) && !inhibit;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msh <= '0; efire <= 1'b0; ecs <= 0; eci <= 0;
        end else begin
            msh   <= {msh[1:0], trig_in};
            efire <= macc;
            ecs   <= macc ? SL : (ecs > 0 ? ecs - 1 : 0);
            eci   <= macc ? IL : (eci > 0 ? eci - 1 : 0);
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk(fire_pulse,  efire,    "R1 R2 R3 R4 R8 fire_pulse");
            chk(stretch_out, ecs != 0, "R5 R6 stretch_out");
            chk(indicator,   eci != 0, "R7 indicator");
        end
    end

    task automatic step(input int mode);
        @(negedge clk);
        case (mode)
            0: inhibit = 1'b0;
            1: inhibit = 1'b1;
            default: inhibit = ~inhibit;
        endcase
    endtask

    task automatic pulse(input int width, input int gap, input int mode);
        trig_in = ~slope_fall;
        for (int i = 0; i < width; i++) step(mode);
        trig_in = slope_fall;
        for (int i = 0; i < gap; i++) step(mode);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs low while reset held
        chk(fire_pulse, 1'b0, "R9 reset fire"); chk(stretch_out, 1'b0, "R9 reset stretch");
        chk(indicator, 1'b0, "R9 reset ind");
        rst_n = 1'b1;
        for (int s = 0; s < 2; s++) begin
            // R8: changing slope moves the idle level; must not fire
            slope_fall = s[0];
            trig_in = slope_fall;
            inhibit = 1'b0;
            repeat (IL + 6) @(negedge clk);
            for (int m = 0; m < 3; m++)
                for (int w = 1; w <= 5; w++)
                    for (int g = 1; g <= 12; g++)
                        pulse(w, g, m);
            inhibit = 1'b0;
            repeat (IL + 6) @(negedge clk);
        end
        // R9: reset in the middle of busy holds
        slope_fall = 1'b0;
        pulse(2, 3, 0);
        rst_n = 1'b0;
        #1;
        chk(fire_pulse, 1'b0, "R9 mid fire"); chk(stretch_out, 1'b0, "R9 mid stretch");
        chk(indicator, 1'b0, "R9 mid ind");
        @(negedge clk); rst_n = 1'b1; trig_in = 1'b0;
        pulse(1, IL + 4, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule